// File: doc/BRIEF.md
# Triggerable Debug Event Down-Counter

This block counts debug events for a processor core. It holds two 16-bit down-counters, called counter 1 and counter 2. They can run apart, or they can be chained into one 32-bit counter in which counter 1 forms the upper half. Each counter decrements at most once per completed instruction, and only when at least one of the events it has enabled was seen during that instruction. The events on the event bus are address compare hits, data compare hits, external events, instruction complete, interrupt taken and return. Events that arrive in the cycles before the completion strobe are collected, so a multi-cycle instruction with several data hits gives a single decrement. An instruction that is aborted gives no decrement.

Counter 1 can be held frozen until a trigger occurs. The trigger is taken from a subset of the events or from the expiry of counter 2. A trigger state machine runs through three states:

- `TRG_OFF`: no trigger is enabled and counter 1 runs freely.
- `TRG_ARMED`: counter 1 is frozen.
- `TRG_FIRED`: counter 1 runs and the trigger status output is high.

The state machine has these transitions:

- `OFF→ARMED` and `FIRED→ARMED`: a configuration write with a nonzero trigger field.
- `any→OFF`: a configuration write with a zero trigger field.
- `ARMED→FIRED`: an enabled trigger source occurs.
- `FIRED→ARMED`: a status-clear write, which re-arms the trigger.

Software loads the configuration and the counts through a single register write port.

Top module: `dbg_event_counter`

## Requirements
- R1: After reset, `cnt_out` is 0, `trig_status` is 0 and both expiry pulses are 0.
- R2: In split mode, `cnt_out[31:16]` is counter 1 and `cnt_out[15:0]` is counter 2. Each counter decrements by one on an `instr_done` cycle without `instr_abort` when `dbg_en` is high and the event set seen for that instruction meets its enables. Both counters may decrement for the same instruction. The event bus bits are:

  | Bit | Event |
  |---|---|
  | 0 | instruction address compare 1 |
  | 1 | instruction address compare 2 |
  | 2 | instruction address compare 3 |
  | 3 | instruction address compare 4 |
  | 4 | data compare 1 read |
  | 5 | data compare 2 read |
  | 6 | data compare 1 write |
  | 7 | data compare 2 write |
  | 8 | external event 1 |
  | 9 | external event 2 |
  | 10 | instruction complete |
  | 11 | interrupt taken |
  | 12 | return |
- R3: Events seen in any cycle from the last completion or abort up to and including the `instr_done` cycle are ORed together, so any number of hits gives a single decrement per counter.
- R4: `instr_abort` discards the collected events and gives no decrement. This holds even when `instr_done` is high in the same cycle.
- R5: No counter changes while `dbg_en` is low, or while its enable field is zero.
- R6: Writing 1 to bit 16 of address 0 selects combined mode. In combined mode, `cnt_out` decrements as one 32-bit value, with a borrow carried from the lower half into the upper half. The counter 1 enables govern this counter, and the counter 2 enables are ignored.
- R7: A counter that holds zero stays at zero. The cycle after a decrement from 1 to 0, the matching expiry output pulses high for one cycle. In combined mode only `c1_expire` pulses.
- R8: The configuration register is written at address 0. Bits 12:0 hold the counter 1 enables. Bits 23:17 hold the trigger enables, in this order:

  | Trigger bit | Source |
  |---|---|
  | 0 | address compare 1 |
  | 1 | address compare 3 |
  | 2 | data compare 1 read |
  | 3 | data compare 1 write |
  | 4 | external event 1 |
  | 5 | external event 2 |
  | 6 | counter 2 expiry |

  A write to address 0 with a nonzero trigger field clears `trig_status` and freezes counter 1. An enabled event source on a counted completion fires the trigger, and that instruction is not counted. Counter 1 counts from the next instruction on, and `trig_status` reads 1.
- R9: When trigger bit 6 is set, a `c2_expire` pulse fires the trigger.
- R10: Writing 1 in bit 0 to address 3 while the trigger has fired clears `trig_status` and freezes counter 1 again.
- R11: Writing to address 2 loads `{counter1, counter2}` from `wr_data`. The load takes priority over a decrement in the same cycle.
- R12: Counter 2 enables are written at address 1, bits 12:0. Counter 2 cannot count on interrupt taken (bit 11) or return (bit 12).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_en | input | 1 | Global debug enable (internal or external debug mode) |
| instr_done | input | 1 | Instruction completion strobe |
| instr_abort | input | 1 | Current instruction interrupted; discard collected events |
| evt | input | 13 | Debug event hits for this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 config 1, 1 config 2, 2 counts, 3 status clear |
| wr_data | input | 32 | Register write data |
| cnt_out | output | 32 | Current counts, {counter1, counter2} |
| trig_status | output | 1 | Counter 1 trigger has fired |
| c1_expire | output | 1 | One-cycle pulse after counter 1 (or the 32-bit counter) reaches 0 |
| c2_expire | output | 1 | One-cycle pulse after counter 2 reaches 0 |

## Verification
The bench targets several corner cases:

- **Hits spread over several cycles of one instruction.** A design that counted per cycle would decrement more than once.
- **An abort that follows collected hits.** A design that leaked pending events would decrement on the next completion.
- **The borrow from the lower to the upper half in combined mode.** A design without the borrow would show a lower half that sticks or wraps alone.
- **The trigger sequence.** It checks that the firing instruction is not counted, that the chained counter 2 expiry fires the trigger, and that re-arming freezes counter 1 again.

Three further cases complete the set:

- **A load in the same cycle as a decrement.** A design with the wrong priority would show the loaded value minus one.
- **A decrement at zero.** A design without the zero hold would wrap to all ones.
- **The barred interrupt and return enables of counter 2.** A design that honoured them would move counter 2.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
    localparam int NEV = 13;
    localparam int NTRG = 7;
    localparam int E_IAC1 = 0;
    localparam int E_IAC3 = 2;
    localparam int E_DAC1R = 4;
    localparam int E_DAC1W = 6;
    localparam int E_EXT1 = 8;
    localparam int E_EXT2 = 9;
    localparam int E_ICMP = 10;
    localparam int T_CNT2 = 6;
    localparam int CFG_MODE_BIT = 16;
    localparam int CFG_TRG_LSB = 17;
    localparam logic [1:0] A_CFG1 = 2'd0;
    localparam logic [1:0] A_CFG2 = 2'd1;
    localparam logic [1:0] A_CNT  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;
    // counter 2 may use every event up to instruction complete
    localparam logic [NEV-1:0] C2_ALLOWED = NEV'((1 << (E_ICMP + 1)) - 1);

    typedef enum logic [1:0] {
        TRG_OFF   = 2'd0,
        TRG_ARMED = 2'd1,
        TRG_FIRED = 2'd2
    } trg_state_e;

    function automatic logic [NEV-1:0] trg_to_evt(input logic [NTRG-1:0] t);
        logic [NEV-1:0] m;
        m = '0;
        m[E_IAC1]  = t[0];
        m[E_IAC3]  = t[1];
        m[E_DAC1R] = t[2];
        m[E_DAC1W] = t[3];
        m[E_EXT1]  = t[4];
        m[E_EXT2]  = t[5];
        return m;
    endfunction
endpackage

// File: rtl/dbgc_evt_acc.sv
module dbgc_evt_acc #(
    parameter int NEV = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] evt,
    input  logic           done,
    input  logic           abort,
    output logic [NEV-1:0] seen,
    output logic           fire
);
    logic [NEV-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= '0;
        else if (done || abort)
            pend_q <= '0;
        else
            pend_q <= pend_q | evt;
    end

    always_comb begin
        seen = pend_q | evt;
        fire = done && !abort;
    end
endmodule

// File: rtl/dbgc_trig_fsm.sv
module dbgc_trig_fsm
    import dbgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_trg_any,
    input  logic       stat_clr,
    input  logic       trig_hit,
    output trg_state_e state,
    output logic       c1_run,
    output logic       trig_status
);
    trg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TRG_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            state_d = cfg_trg_any ? TRG_ARMED : TRG_OFF;
        end else begin
            unique case (state_q)
                TRG_OFF:   state_d = TRG_OFF;
                TRG_ARMED: if (trig_hit) state_d = TRG_FIRED;
                TRG_FIRED: if (stat_clr) state_d = TRG_ARMED;
                default:   state_d = TRG_OFF;
            endcase
        end
    end

    always_comb begin
        state       = state_q;
        c1_run      = 1'b1;
        trig_status = 1'b0;
        unique case (state_q)
            TRG_OFF:   c1_run = 1'b1;
            TRG_ARMED: c1_run = 1'b0;
            TRG_FIRED: trig_status = 1'b1;
            default:   c1_run = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbgc_down_cnt.sv
module dbgc_down_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         dec,
    input  logic         wrap_ok,
    output logic [W-1:0] cnt,
    output logic         borrow
);
    logic [W-1:0] cnt_q;
    logic         is_zero;

    assign is_zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (ld)
            cnt_q <= ld_val;
        else if (dec && !is_zero)
            cnt_q <= cnt_q - W'(1);
        else if (dec && wrap_ok)
            cnt_q <= '1;
    end

    assign cnt    = cnt_q;
    assign borrow = dec && !ld && is_zero && wrap_ok;
endmodule

// File: rtl/dbg_event_counter.sv
module dbg_event_counter
    import dbgc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dbg_en,
    input  logic            instr_done,
    input  logic            instr_abort,
    input  logic [NEV-1:0]  evt,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [2*CW-1:0] wr_data,
    output logic [2*CW-1:0] cnt_out,
    output logic            trig_status,
    output logic            c1_expire,
    output logic            c2_expire
);
    localparam int DW = 2 * CW;

    logic [NEV-1:0]  c1_en_q, c2_en_q, seen;
    logic [NTRG-1:0] trg_en_q;
    logic            comb_q, fire, c1_run, trig_hit;
    logic            wr_cfg1, wr_cfg2, wr_cnt, wr_stat;
    logic            c1_dec, c2_dec, hi_dec, lo_dec, lo_wrap, lo_borrow, hi_borrow;
    logic [CW-1:0]   hi_cnt, lo_cnt;
    logic            e1_q, e2_q;
    trg_state_e      trg_state;

    assign wr_cfg1 = wr_en && (wr_addr == A_CFG1);
    assign wr_cfg2 = wr_en && (wr_addr == A_CFG2);
    assign wr_cnt  = wr_en && (wr_addr == A_CNT);
    assign wr_stat = wr_en && (wr_addr == A_STAT) && wr_data[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1_en_q  <= '0;
            c2_en_q  <= '0;
            trg_en_q <= '0;
            comb_q   <= 1'b0;
        end else begin
            if (wr_cfg1) begin
                c1_en_q  <= wr_data[NEV-1:0];
                comb_q   <= wr_data[CFG_MODE_BIT];
                trg_en_q <= wr_data[CFG_TRG_LSB +: NTRG];
            end
            if (wr_cfg2)
                c2_en_q <= wr_data[NEV-1:0];
        end
    end

    dbgc_evt_acc #(.NEV(NEV)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .done  (instr_done),
        .abort (instr_abort),
        .seen  (seen),
        .fire  (fire)
    );

    assign trig_hit = (fire && |(seen & trg_to_evt(trg_en_q)))
                   || (trg_en_q[T_CNT2] && e2_q);

    dbgc_trig_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (wr_cfg1),
        .cfg_trg_any (|wr_data[CFG_TRG_LSB +: NTRG]),
        .stat_clr    (wr_stat),
        .trig_hit    (trig_hit),
        .state       (trg_state),
        .c1_run      (c1_run),
        .trig_status (trig_status)
    );

    assign c1_dec = fire && dbg_en && c1_run && !wr_cnt && |(seen & c1_en_q);
    assign c2_dec = fire && dbg_en && !comb_q && !wr_cnt
                 && |(seen & c2_en_q & C2_ALLOWED);

    assign lo_dec  = comb_q ? c1_dec : c2_dec;
    assign lo_wrap = comb_q && (hi_cnt != '0);
    assign hi_dec  = comb_q ? lo_borrow : c1_dec;

    dbgc_down_cnt #(.W(CW)) u_lo (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (wr_cnt),
        .ld_val (wr_data[CW-1:0]),
        .dec    (lo_dec),
        .wrap_ok(lo_wrap),
        .cnt    (lo_cnt),
        .borrow (lo_borrow)
    );

    dbgc_down_cnt #(.W(CW)) u_hi (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (wr_cnt),
        .ld_val (wr_data[DW-1:CW]),
        .dec    (hi_dec),
        .wrap_ok(1'b0),
        .cnt    (hi_cnt),
        .borrow (hi_borrow)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e1_q <= 1'b0;
            e2_q <= 1'b0;
        end else begin
            e1_q <= comb_q ? (c1_dec && ({hi_cnt, lo_cnt} == DW'(1)))
                           : (c1_dec && (hi_cnt == CW'(1)));
            e2_q <= c2_dec && (lo_cnt == CW'(1));
        end
    end

    assign cnt_out   = {hi_cnt, lo_cnt};
    assign c1_expire = e1_q;
    assign c2_expire = e2_q;
endmodule

// File: rtl/dbgc_counter_chk.sv
module dbgc_counter_chk
    import dbgc_pkg::*;
#(
    parameter int CW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dbg_en,
    input logic            wr_en,
    input logic [1:0]      wr_addr,
    input logic [2*CW-1:0] wr_data,
    input logic [2*CW-1:0] cnt_out,
    input logic            trig_status,
    input logic            c1_expire,
    input logic            comb_q,
    input logic [1:0]      trg_state,
    input logic            c1_dec
);
    logic ld;
    assign ld = wr_en && (wr_addr == A_CNT);

    AST_DISABLED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_en && !ld) |=> $stable(cnt_out)); // R5

    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !comb_q) |=> ((cnt_out[2*CW-1:CW] == $past(cnt_out[2*CW-1:CW]))
            || (cnt_out[2*CW-1:CW] == CW'($past(cnt_out[2*CW-1:CW]) - CW'(1))))); // R3

    AST_ZERO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !comb_q && cnt_out[CW-1:0] == '0) |=> (cnt_out[CW-1:0] == '0)); // R7

    AST_EXPIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (c1_expire && !comb_q) |-> (cnt_out[2*CW-1:CW] == '0)); // R7

    AST_FROZEN_NO_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_state == 2'd1) |-> !c1_dec); // R8

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CFG1 && |wr_data[CFG_TRG_LSB +: NTRG]) |=> !trig_status); // R8

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (cnt_out == $past(wr_data))); // R11
endmodule

bind dbg_event_counter dbgc_counter_chk #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dbg_en      (dbg_en),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .cnt_out     (cnt_out),
    .trig_status (trig_status),
    .c1_expire   (c1_expire),
    .comb_q      (comb_q),
    .trg_state   (trg_state),
    .c1_dec      (c1_dec)
);

// File: tb/dbg_event_counter_tb.sv
module dbg_event_counter_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_dbg = 1'b1, i_done = 1'b0, i_abort = 1'b0, i_wr = 1'b0;
    logic [12:0] i_evt = '0;
    logic [1:0]  i_addr = '0;
    logic [31:0] i_data = '0;
    logic [31:0] cnt_out;
    logic        trig_status, c1_expire, c2_expire;

    int total = 0, bad = 0;
    string cur_req = "R1";

    // reference state
    logic [15:0] m_c1 = '0, m_c2 = '0;
    logic [12:0] m_c1en = '0, m_c2en = '0, m_pend = '0;
    logic [6:0]  m_trg = '0;
    logic        m_comb = 1'b0, m_e1 = 1'b0, m_e2 = 1'b0;
    int          m_st = 0; // 0 off, 1 armed, 2 fired

    always #(PERIOD/2) clk = ~clk;

    dbg_event_counter u_dut (
        .clk(clk), .rst_n(rst_n), .dbg_en(i_dbg), .instr_done(i_done),
        .instr_abort(i_abort), .evt(i_evt), .wr_en(i_wr), .wr_addr(i_addr),
        .wr_data(i_data), .cnt_out(cnt_out), .trig_status(trig_status),
        .c1_expire(c1_expire), .c2_expire(c2_expire)
    );

    function automatic logic [12:0] tmask(input logic [6:0] t);
        return {3'b000, t[5], t[4], 1'b0, t[3], 1'b0, t[2], 1'b0, t[1], 1'b0, t[0]};
    endfunction

    task automatic model_edge();
        logic [12:0] seen;
        logic fire, ldw, hit, c1d, c2d, ne1, ne2;
        logic [31:0] tot;
        seen = i_evt | m_pend;
        fire = i_done && !i_abort;
        ldw  = i_wr && i_addr == 2'd2;
        hit  = (fire && |(seen & tmask(m_trg))) || (m_trg[6] && m_e2);
        c1d  = fire && i_dbg && |(seen & m_c1en) && (m_st != 1) && !ldw;
        c2d  = !m_comb && fire && i_dbg && |(seen & m_c2en & 13'h07FF) && !ldw;
        tot  = {m_c1, m_c2};
        ne1  = m_comb ? (c1d && tot == 32'd1) : (c1d && m_c1 == 16'd1);
        ne2  = c2d && m_c2 == 16'd1;
        if (ldw) begin
            m_c1 = i_data[31:16]; m_c2 = i_data[15:0];
        end else if (m_comb) begin
            if (c1d && tot != 0) {m_c1, m_c2} = tot - 32'd1;
        end else begin
            if (c1d && m_c1 != 0) m_c1 = m_c1 - 16'd1;
            if (c2d && m_c2 != 0) m_c2 = m_c2 - 16'd1;
        end
        if (i_wr && i_addr == 2'd0) m_st = (i_data[23:17] != 0) ? 1 : 0;
        else if (i_wr && i_addr == 2'd3 && i_data[0] && m_st == 2) m_st = 1;
        else if (m_st == 1 && hit) m_st = 2;
        if (i_wr && i_addr == 2'd0) begin
            m_c1en = i_data[12:0]; m_comb = i_data[16]; m_trg = i_data[23:17];
        end
        if (i_wr && i_addr == 2'd1) m_c2en = i_data[12:0];
        m_pend = (i_done || i_abort) ? 13'd0 : (m_pend | i_evt);
        m_e1 = ne1; m_e2 = ne2;
    endtask

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("count", cnt_out, {m_c1, m_c2});
        chk("trig_status", {31'd0, trig_status}, {31'd0, m_st == 2});
        chk("c1_expire", {31'd0, c1_expire}, {31'd0, m_e1});
        chk("c2_expire", {31'd0, c2_expire}, {31'd0, m_e2});
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
        i_done = 0; i_abort = 0; i_wr = 0; i_evt = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        i_wr = 1; i_addr = a; i_data = d; cyc();
    endtask

    task automatic instr(input logic [12:0] e);
        i_evt = e; i_done = 1; cyc();
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1"; compare();
        // R2 split counting, both counters on one instruction
        cur_req = "R2";
        wr(2'd0, 32'h0000_0001);
        wr(2'd1, 32'h0000_0400);
        wr(2'd2, 32'h0005_0003);
        instr(13'h401); instr(13'h401); instr(13'h001);
        // R3 hits over several cycles count once
        cur_req = "R3";
        wr(2'd0, 32'h0000_000F);
        i_evt = 13'h001; cyc(); i_evt = 13'h004; cyc();
        instr(13'h002); idle(1);
        // R4 abort discards collected hits
        cur_req = "R4";
        i_evt = 13'h001; cyc(); i_abort = 1; cyc(); instr(13'h000);
        i_evt = 13'h001; i_done = 1; i_abort = 1; cyc(); idle(1);
        // R5 global enable low, empty enable field
        cur_req = "R5";
        i_dbg = 0; instr(13'h401); i_dbg = 1;
        wr(2'd0, 32'h0); instr(13'h001);
        // R12 counter 2 ignores interrupt and return
        cur_req = "R12";
        wr(2'd1, 32'h0000_1800); instr(13'h1800); instr(13'h0800);
        // R6 combined mode with borrow, counter 2 enables ignored
        cur_req = "R6";
        wr(2'd1, 32'h0000_0400);
        wr(2'd0, 32'h0001_0001);
        wr(2'd2, 32'h0001_0000);
        instr(13'h001); instr(13'h400); instr(13'h001);
        // R7 expiry pulses and zero hold
        cur_req = "R7";
        wr(2'd2, 32'h0000_0001); instr(13'h001); instr(13'h001); idle(1);
        wr(2'd0, 32'h0000_0001);
        wr(2'd2, 32'h0001_0001); instr(13'h401); idle(1); instr(13'h401); idle(1);
        // R8 trigger on external event 1
        cur_req = "R8";
        wr(2'd2, 32'h0005_0005);
        wr(2'd0, 32'h0020_0001);
        instr(13'h001); instr(13'h101); instr(13'h001); idle(1);
        // R10 re-arm by clearing status
        cur_req = "R10";
        wr(2'd3, 32'h1); instr(13'h001); instr(13'h101); instr(13'h001);
        // R9 trigger from counter 2 expiry
        cur_req = "R9";
        wr(2'd0, 32'h0080_0001);
        wr(2'd2, 32'h0005_0001);
        instr(13'h401); idle(2); instr(13'h001);
        // R11 load beats decrement
        cur_req = "R11";
        i_wr = 1; i_addr = 2'd2; i_data = 32'h0009_0009; i_evt = 13'h401; i_done = 1; cyc();
        instr(13'h401);
        // random phase, all requirements (R2 tag)
        cur_req = "R2-rnd";
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            i_dbg = ($urandom_range(0, 9) != 0);
            if (r < 4) begin
                i_wr = 1; i_addr = 2'($urandom_range(0, 3));
                i_data = $urandom();
                if (i_addr == 2'd2) i_data = {13'd0, 3'($urandom_range(0, 5)), 13'd0, 3'($urandom_range(0, 5))};
                if (i_addr == 2'd0 && $urandom_range(0, 1) == 0) i_data[23:17] = '0;
            end
            i_evt = ($urandom_range(0, 2) == 0) ? 13'($urandom()) : 13'd0;
            i_done = ($urandom_range(0, 2) == 0);
            i_abort = ($urandom_range(0, 15) == 0);
            cyc();
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule